// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Arbiter

This block sits between the processors of a small cluster and their interrupt controllers. A local processor writes a 64-bit interrupt command word and pulses a write strobe. In the same cycle the block decodes the word and compares the addressing fields against the identity and logical addressing state of every agent. One cycle later it raises a request bit for each agent that must take the interrupt. It also presents the vector, the delivery mode, the level and the trigger fields that go with the request.

Addressing can be physical, meaning an exact ID compare. It can be logical, in either a flat bit-mask model or a cluster/member model. It can also be bypassed by a shorthand: self, everyone, or everyone except the sender. Lowest-priority delivery reduces the set of matching agents to one agent. The block keeps a rotating pointer per vector so that repeated interrupts on one vector spread over the eligible agents. A broadcast in cluster model with lowest-priority delivery has no defined single target. It is reported on an error output and nothing is delivered.

The stored command can be read back. The delivery-status bit reads as zero because dispatch never waits. Only the destination byte of the upper word is kept.

Top module: `ipi_dest_arbiter`

## Requirements
- R1: `req` is zero in every cycle that does not directly follow a cycle with `cmd_wr` high. After a write, `req_vec` (low word bits 7:0), `req_dlv` (bits 10:8), `req_level` (bit 14) and `req_trig` (bit 15) show the written command from the next cycle on, and they hold until the next write.
- R2: After a write, `cmd_lo_rd` equals the written low word with bit 12 forced to 0. `cmd_hi_rd` equals the written bits 31:24 of the high word, with bits 23:0 reading 0.
- R3: With no shorthand (low word bits 19:18 = 0) and physical addressing (bit 11 = 0), an agent matches when its 8-bit ID equals the destination byte (high word bits 31:24).
- R4: With logical addressing (bit 11 = 1), an agent whose format nibble is 4'hF uses the flat model. It matches when its logical byte ANDed with the destination byte is nonzero.
- R5: An agent with any other format nibble uses the cluster model. Its logical byte holds the cluster in bits 3:0 and the member mask in bits 7:4. It matches when the cluster equals destination bits 3:0 and the member mask ANDed with destination bits 7:4 is nonzero.
- R6: Shorthand 1 targets only the agent at `sender_idx`. Shorthand 2 targets all agents. Shorthand 3 targets all agents except the sender. The destination byte is ignored under every shorthand.
- R7: An agent whose `agent_en` bit is 0 is never requested, and it is never part of a lowest-priority choice.
- R8: For delivery mode 1 (lowest priority) with logical addressing, exactly one matching agent is requested. The search starts at the agent after the one last chosen for that vector and wraps at N_AGENTS back to 0. The chosen agent becomes the new last choice for that vector only. After reset every vector's last choice is agent 0.
- R9: Lowest-priority delivery with physical addressing, or with no matching agent, requests nobody and leaves the last choice unchanged.
- R10: Lowest-priority delivery with no shorthand, logical addressing and destination 8'hFF raises `lp_bcast_err` for one cycle, provided at least one enabled agent uses the cluster model. In that case nobody is requested and the last choice is unchanged.
- R11: Delivery mode 3 is reserved and requests nobody. Every other mode except 1 requests every matching agent.
- R12: During and right after reset, `req`, `lp_bcast_err`, the readback words and the field outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_wr | input | 1 | Command write strobe, one cycle per command |
| cmd_lo | input | 32 | Low command word: vector, mode, addressing and shorthand fields |
| cmd_hi | input | 32 | High command word: destination byte in bits 31:24 |
| sender_idx | input | $clog2(N_AGENTS) | Index of the agent issuing the command |
| agent_id | input | 8*N_AGENTS | Packed 8-bit physical IDs, agent k in bits 8k+7:8k |
| agent_ldest | input | 8*N_AGENTS | Packed 8-bit logical destination bytes |
| agent_fmt | input | 4*N_AGENTS | Packed destination format nibbles (4'hF = flat) |
| agent_en | input | N_AGENTS | Per-agent enabled flag |
| req | output | N_AGENTS | Per-agent delivery request, pulsed for one cycle |
| req_vec | output | 8 | Vector of the last command |
| req_dlv | output | 3 | Delivery mode of the last command |
| req_level | output | 1 | Level field of the last command |
| req_trig | output | 1 | Trigger field of the last command |
| lp_bcast_err | output | 1 | Pulsed when a cluster lowest-priority broadcast is refused |
| cmd_lo_rd | output | 32 | Readback of the stored low word |
| cmd_hi_rd | output | 32 | Readback of the stored high word |

## Verification
A single command write can fall into two functions at once: the lowest-priority rotation and the cluster-broadcast refusal. The rotation pointer moves only when a choice is delivered. So the bench sends refused broadcasts and physical-mode lowest-priority commands on a vector, in between normal rotating commands on that same vector. It then judges from the agent chosen by the next normal command that the pointer did not move. The same collision also occurs between shorthands and the enable mask. Randomly disabled agents are mixed with all shorthands, and each request pattern is compared with the bench's own match model.

// File: rtl/ipi_arb_pkg.sv
package ipi_arb_pkg;

  localparam int CMD_VEC_W = 8;
  localparam int DEST_W    = 8;
  localparam int FMT_W     = 4;

  localparam logic [2:0] DLV_LOWPRI = 3'd1;
  localparam logic [2:0] DLV_RSVD   = 3'd3;
  localparam logic [3:0] FMT_FLAT   = 4'hF;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [DEST_W-1:0]    dest;
    shorthand_e           sh;
    logic                 trig;
    logic                 level;
    logic                 logical;
    logic [2:0]           dlv;
    logic [CMD_VEC_W-1:0] vec;
  } ipi_cmd_t;

  function automatic ipi_cmd_t split_cmd(input logic [31:0] lo, input logic [31:0] hi);
    ipi_cmd_t c;
    c.dest    = hi[31:24];
    c.sh      = shorthand_e'(lo[19:18]);
    c.trig    = lo[15];
    c.level   = lo[14];
    c.logical = lo[11];
    c.dlv     = lo[10:8];
    c.vec     = lo[7:0];
    return c;
  endfunction

endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] lo,
  input  logic [31:0] hi,
  output logic [31:0] lo_q,
  output logic [31:0] hi_q
);
  localparam logic [31:0] LO_KEEP = ~(32'h1 << 12);
  localparam logic [31:0] HI_KEEP = 32'hFF00_0000;

  logic [31:0] lo_d, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (wr) begin
      lo_d = lo & LO_KEEP;
      hi_d = hi & HI_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match #(
  parameter int N_AGENTS = 8,
  localparam int AW = $clog2(N_AGENTS)
) (
  input  logic [7:0]            dest,
  input  logic [1:0]            sh,
  input  logic                  logical,
  input  logic [AW-1:0]         sender,
  input  logic [8*N_AGENTS-1:0] ids,
  input  logic [8*N_AGENTS-1:0] ldest,
  input  logic [4*N_AGENTS-1:0] fmt,
  input  logic [N_AGENTS-1:0]   en,
  output logic [N_AGENTS-1:0]   match,
  output logic                  cluster_any
);
  import ipi_arb_pkg::*;

  logic [N_AGENTS-1:0] is_cluster;

  for (genvar a = 0; a < N_AGENTS; a++) begin : g_agent
    logic [7:0] my_id, my_ld;
    logic [3:0] my_fmt;
    logic       addr_hit, is_self, raw;

    assign my_id  = ids[8*a +: 8];
    assign my_ld  = ldest[8*a +: 8];
    assign my_fmt = fmt[4*a +: 4];
    assign is_self = (sender == AW'(a));

    always_comb begin
      if (!logical)
        addr_hit = (my_id == dest);
      else if (my_fmt == FMT_FLAT)
        addr_hit = |(my_ld & dest);
      else
        addr_hit = (my_ld[3:0] == dest[3:0]) && |(my_ld[7:4] & dest[7:4]);
    end

    always_comb begin
      unique case (shorthand_e'(sh))
        SH_NONE:   raw = addr_hit;
        SH_SELF:   raw = is_self;
        SH_ALL:    raw = 1'b1;
        SH_OTHERS: raw = !is_self;
        default:   raw = 1'b0;
      endcase
    end

    assign match[a]      = raw && en[a];
    assign is_cluster[a] = en[a] && (my_fmt != FMT_FLAT);
  end

  assign cluster_any = |is_cluster;
endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int N_AGENTS = 8,
  parameter int N_VEC    = 256,
  localparam int AW = $clog2(N_AGENTS),
  localparam int VW = $clog2(N_VEC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd,
  input  logic [VW-1:0]       vec,
  input  logic [N_AGENTS-1:0] bitmap,
  output logic [N_AGENTS-1:0] pick,
  output logic                hit
);
  localparam logic [N_AGENTS-1:0] ONE = N_AGENTS'(1);

  logic [AW-1:0] last_q [N_VEC];
  logic [AW-1:0] last_d [N_VEC];
  logic [AW-1:0] base, pick_idx;

  assign base = last_q[vec];

  always_comb begin
    hit      = 1'b0;
    pick_idx = '0;
    for (int k = 1; k <= N_AGENTS; k++) begin
      logic [AW-1:0] idx;
      idx = AW'((int'(base) + k) % N_AGENTS);
      if (!hit && bitmap[idx]) begin
        hit      = 1'b1;
        pick_idx = idx;
      end
    end
    pick = hit ? (ONE << pick_idx) : '0;
  end

  always_comb begin
    for (int v = 0; v < N_VEC; v++)
      last_d[v] = (upd && hit && (vec == VW'(v))) ? pick_idx : last_q[v];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < N_VEC; v++) last_q[v] <= '0;
    end else begin
      for (int v = 0; v < N_VEC; v++) last_q[v] <= last_d[v];
    end
  end
endmodule

// File: rtl/ipi_dest_arbiter.sv
module ipi_dest_arbiter #(
  parameter int N_AGENTS = 8,
  localparam int AW = $clog2(N_AGENTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_wr,
  input  logic [31:0]           cmd_lo,
  input  logic [31:0]           cmd_hi,
  input  logic [AW-1:0]         sender_idx,
  input  logic [8*N_AGENTS-1:0] agent_id,
  input  logic [8*N_AGENTS-1:0] agent_ldest,
  input  logic [4*N_AGENTS-1:0] agent_fmt,
  input  logic [N_AGENTS-1:0]   agent_en,
  output logic [N_AGENTS-1:0]   req,
  output logic [7:0]            req_vec,
  output logic [2:0]            req_dlv,
  output logic                  req_level,
  output logic                  req_trig,
  output logic                  lp_bcast_err,
  output logic [31:0]           cmd_lo_rd,
  output logic [31:0]           cmd_hi_rd
);
  import ipi_arb_pkg::*;

  localparam int N_VEC = 1 << CMD_VEC_W;

  ipi_cmd_t            cmd;
  logic [N_AGENTS-1:0] match, lp_pick, req_d;
  logic                cluster_any, lp_hit, is_lp, lp_refuse, lp_go, err_d;

  assign cmd = split_cmd(cmd_lo, cmd_hi);

  ipi_cmd_regs u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (cmd_wr),
    .lo   (cmd_lo),
    .hi   (cmd_hi),
    .lo_q (cmd_lo_rd),
    .hi_q (cmd_hi_rd)
  );

  ipi_dest_match #(.N_AGENTS(N_AGENTS)) u_match (
    .dest       (cmd.dest),
    .sh         (cmd.sh),
    .logical    (cmd.logical),
    .sender     (sender_idx),
    .ids        (agent_id),
    .ldest      (agent_ldest),
    .fmt        (agent_fmt),
    .en         (agent_en),
    .match      (match),
    .cluster_any(cluster_any)
  );

  assign is_lp     = (cmd.dlv == DLV_LOWPRI);
  assign lp_refuse = is_lp && (cmd.sh == SH_NONE) && cmd.logical &&
                     (cmd.dest == 8'hFF) && cluster_any;
  assign lp_go     = cmd_wr && is_lp && cmd.logical && !lp_refuse;

  ipi_rr_pick #(.N_AGENTS(N_AGENTS), .N_VEC(N_VEC)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (lp_go),
    .vec   (cmd.vec),
    .bitmap(match),
    .pick  (lp_pick),
    .hit   (lp_hit)
  );

  always_comb begin
    req_d = '0;
    err_d = 1'b0;
    if (cmd_wr) begin
      if (is_lp) begin
        err_d = lp_refuse;
        if (lp_go && lp_hit) req_d = lp_pick;
      end else if (cmd.dlv != DLV_RSVD) begin
        req_d = match;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req          <= '0;
      lp_bcast_err <= 1'b0;
    end else begin
      req          <= req_d;
      lp_bcast_err <= err_d;
    end
  end

  assign req_vec   = cmd_lo_rd[7:0];
  assign req_dlv   = cmd_lo_rd[10:8];
  assign req_level = cmd_lo_rd[14];
  assign req_trig  = cmd_lo_rd[15];
endmodule

// File: rtl/ipi_dest_arbiter_chk.sv
module ipi_dest_arbiter_chk #(
  parameter int N_AGENTS = 8,
  localparam int AW = $clog2(N_AGENTS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_wr,
  input logic [31:0]         cmd_lo,
  input logic [31:0]         cmd_hi,
  input logic [AW-1:0]       sender_idx,
  input logic [N_AGENTS-1:0] agent_en,
  input logic [N_AGENTS-1:0] req,
  input logic                lp_bcast_err,
  input logic [31:0]         cmd_lo_rd,
  input logic [31:0]         cmd_hi_rd
);
  localparam logic [N_AGENTS-1:0] ONE = N_AGENTS'(1);

  // R1
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (req == '0));

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (cmd_lo_rd[31:13] == $past(cmd_lo[31:13])) && !cmd_lo_rd[12] &&
               (cmd_lo_rd[11:0] == $past(cmd_lo[11:0])) &&
               (cmd_hi_rd == {$past(cmd_hi[31:24]), 24'h0}));

  // R6
  self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_lo[19:18] == 2'd1 && cmd_lo[10:8] != 3'd1) |=>
      ((req & ~(ONE << $past(sender_idx))) == '0));

  // R7
  enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> ((req & ~$past(agent_en)) == '0));

  // R8
  lp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_lo[10:8] == 3'd1) |=> $onehot0(req));

  // R9
  lp_phys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_lo[10:8] == 3'd1 && !cmd_lo[11]) |=> (req == '0));

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_bcast_err |-> (req == '0));

  // R11
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_lo[10:8] == 3'd3) |=> (req == '0) && !lp_bcast_err);
endmodule

bind ipi_dest_arbiter ipi_dest_arbiter_chk #(.N_AGENTS(N_AGENTS)) u_chk (.*);

// File: tb/ipi_dest_arbiter_test.sv
`timescale 1ns/1ps
module ipi_dest_arbiter_test;
  localparam int NA = 8;
  localparam int AW = 3;
  localparam time TCK = 20ns;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cmd_wr;
  logic [31:0]     cmd_lo, cmd_hi;
  logic [AW-1:0]   sender_idx;
  logic [8*NA-1:0] agent_id, agent_ldest;
  logic [4*NA-1:0] agent_fmt;
  logic [NA-1:0]   agent_en;
  logic [NA-1:0]   req;
  logic [7:0]      req_vec;
  logic [2:0]      req_dlv;
  logic            req_level, req_trig, lp_bcast_err;
  logic [31:0]     cmd_lo_rd, cmd_hi_rd;

  logic [7:0] ids [NA];
  logic [7:0] ld  [NA];
  logic [3:0] fm  [NA];
  int lp_last [256];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(TCK/2) clk = ~clk;

  always_comb begin
    for (int a = 0; a < NA; a++) begin
      agent_id[8*a +: 8]    = ids[a];
      agent_ldest[8*a +: 8] = ld[a];
      agent_fmt[4*a +: 4]   = fm[a];
    end
  end

  ipi_dest_arbiter #(.N_AGENTS(NA)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [NA-1:0] model_match(input logic [31:0] lo, input logic [31:0] hi,
                                                input int snd);
    logic [NA-1:0] m = '0;
    logic [7:0] d = hi[31:24];
    for (int a = 0; a < NA; a++) begin
      logic hit;
      case (lo[19:18])
        2'd0: if (!lo[11]) hit = (ids[a] == d);
              else if (fm[a] == 4'hF) hit = |(ld[a] & d);
              else hit = (ld[a][3:0] == d[3:0]) && |(ld[a][7:4] & d[7:4]);
        2'd1: hit = (a == snd);
        2'd2: hit = 1'b1;
        default: hit = (a != snd);
      endcase
      m[a] = hit && agent_en[a];
    end
    return m;
  endfunction

  task automatic model(input logic [31:0] lo, input logic [31:0] hi, input int snd,
                       output logic [NA-1:0] ereq, output logic eerr);
    logic [NA-1:0] m = model_match(lo, hi, snd);
    logic cl_any = 1'b0;
    int v = lo[7:0];
    bit found = 0;
    for (int a = 0; a < NA; a++) if (agent_en[a] && fm[a] != 4'hF) cl_any = 1'b1;
    ereq = '0;
    eerr = 1'b0;
    if (lo[10:8] == 3'd3) ereq = '0;
    else if (lo[10:8] == 3'd1) begin
      if (lo[19:18] == 2'd0 && lo[11] && hi[31:24] == 8'hFF && cl_any) eerr = 1'b1;
      else if (lo[11]) begin
        for (int k = 1; k <= NA; k++) begin
          int idx = (lp_last[v] + k) % NA;
          if (!found && m[idx]) begin
            found = 1;
            ereq = NA'(1) << idx;
          end
        end
        if (found) lp_last[v] = $clog2(int'(ereq));
      end
    end else ereq = m;
  endtask

  task automatic send(input string tag, input logic [31:0] lo, input logic [31:0] hi,
                      input int snd);
    logic [NA-1:0] ereq;
    logic eerr;
    model(lo, hi, snd, ereq, eerr);
    @(negedge clk);
    cmd_lo = lo; cmd_hi = hi; sender_idx = AW'(snd); cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk({tag, " req"}, 32'(req), 32'(ereq));
    chk({tag, " err R10"}, 32'(lp_bcast_err), 32'(eerr));
    chk("R2 lo readback", cmd_lo_rd, lo & ~32'h1000);
    chk("R2 hi readback", cmd_hi_rd, {hi[31:24], 24'h0});
    chk("R1 fields", {17'h0, req_trig, req_level, req_dlv, 1'b0, req_vec},
        {17'h0, lo[15], lo[14], lo[10:8], 1'b0, lo[7:0]});
  endtask

  task automatic flat_cfg();
    for (int a = 0; a < NA; a++) begin
      ids[a] = 8'h10 + 8'(a);
      ld[a]  = 8'(1 << a);
      fm[a]  = 4'hF;
    end
    agent_en = '1;
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int v = 0; v < 256; v++) lp_last[v] = 0;
    flat_cfg();
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_lo = '0; cmd_hi = '0; sender_idx = '0;
    repeat (3) @(negedge clk);
    chk("R12 reset req", 32'(req), 0);
    chk("R12 reset err", 32'(lp_bcast_err), 0);
    chk("R12 reset lo", cmd_lo_rd, 0);
    chk("R12 reset hi", cmd_hi_rd, 0);
    chk("R12 reset fields", {req_trig, req_level, req_dlv, req_vec}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 readback with delivery-status bit set and low high-word bits set
    send("R2", 32'h0000_D030, 32'h12AB_CDEF, 0);
    @(negedge clk);
    chk("R1 pulse drop", 32'(req), 0);
    send("R3 physical", 32'h0000_C031, 32'h1300_0000, 0);
    send("R3 physical miss", 32'h0000_0031, 32'h2000_0000, 0);
    send("R4 flat", 32'h0000_0831, 32'h0500_0000, 1);
    send("R6 self", 32'h0004_0031, 32'h1300_0000, 5);
    send("R6 all", 32'h0008_0031, 32'h0000_0000, 5);
    send("R6 others", 32'h000C_0031, 32'h1300_0000, 3);
    agent_en[2] = 1'b0;
    send("R7 disabled all", 32'h0008_0032, 32'h0, 0);
    send("R7 disabled phys", 32'h0000_0032, 32'h1200_0000, 0);
    agent_en[2] = 1'b1;
    // R8 rotation on vector 0x55 over agents 0..3, then an independent vector
    for (int i = 0; i < 5; i++) send("R8 rotate", 32'h0000_0955, 32'h0F00_0000, 0);
    send("R8 other vector", 32'h0000_0956, 32'h0F00_0000, 0);
    // R9 physical and empty leave the pointer untouched
    send("R9 physical", 32'h0000_0155, 32'h1000_0000, 0);
    send("R9 empty", 32'h0000_0955, 32'h0000_0000, 0);
    send("R9 after", 32'h0000_0955, 32'h0F00_0000, 0);
    // R5 cluster model on agents 4..7
    fm[4] = 4'h0; ld[4] = 8'h11;
    fm[5] = 4'h0; ld[5] = 8'h21;
    fm[6] = 4'h0; ld[6] = 8'h12;
    fm[7] = 4'h0; ld[7] = 8'h22;
    send("R5 cluster", 32'h0000_0831, 32'h3100_0000, 0);
    send("R5 cluster 2", 32'h0000_0831, 32'h2200_0000, 0);
    send("R10 broadcast", 32'h0000_0955, 32'hFF00_0000, 0);
    send("R10 pointer kept", 32'h0000_0955, 32'h0F00_0000, 0);
    send("R11 reserved", 32'h0008_0331, 32'h0, 0);
    send("R11 nmi", 32'h0008_0431, 32'h0, 0);

    for (int n = 0; n < 400; n++) begin
      if (n % 20 == 0) begin
        for (int a = 0; a < NA; a++) begin
          ids[a] = 8'($urandom_range(0, 7));
          ld[a]  = 8'($urandom);
          fm[a]  = ($urandom_range(0, 2) == 0) ? 4'h0 : 4'hF;
        end
        agent_en = NA'($urandom) | NA'($urandom);
      end
      begin
        logic [31:0] lo, hi;
        logic [2:0] dl;
        logic [7:0] d;
        dl = 3'($urandom_range(0, 4));
        d  = ($urandom_range(0, 9) == 0) ? 8'hFF : 8'($urandom);
        if ($urandom_range(0, 1) == 1 && !(d == 8'hFF)) d = 8'($urandom_range(0, 7));
        lo = $urandom;
        lo[10:8] = dl;
        lo[7:0]  = 8'h60 + 8'($urandom_range(0, 3));
        if ($urandom_range(0, 1) == 1) lo[19:18] = 2'd0;
        hi = {d, 24'($urandom)};
        send("R3-R11 random", lo, hi, int'($urandom_range(0, NA - 1)));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule